// File: doc/BRIEF.md
# Bidirectional Reset Pulse Controller

This block manages one open-drain line that can serve two purposes. On the output side, software sets a request bit and the block pulls the line low for a fixed, minimum-length interval. The block then raises a one-cycle strobe that tells the register file to clear the request bit. A pulse is only produced when a separate enable bit, held in an interrupt mask register, is 1. If software requests a pulse while that enable is 0, the block clears the request bit without pulsing.

On the input side, the block watches the line whenever it is not driving a pulse. The line is synchronized through a flop chain. A low level on the line produces a single register-reset strobe for each low episode, which returns the register file to its power-on defaults. For value storage the reset is selective: a per-slot clear vector asserts only the bit of the converter-data slot, so every other slot keeps its contents. The block masks its own driven low, plus a short blanking window after releasing the line, so that it never resets itself.

Top module: `rstpin_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, `pin_pull_low`, `req_clear`, `regs_rst` and every bit of `ram_clr` are 0.
- R2: When `pulse_req` and `pulse_en` are both 1 at a clock edge in the idle state, `pin_pull_low` is 1 from the cycle after that edge.
- R3: `pin_pull_low` stays 1 for exactly `PULSE_CYCLES` consecutive cycles. The default value of 2,500,000 equals 20 ms at 125 MHz.
- R4: In the cycle right after `pin_pull_low` returns to 0, `req_clear` is 1 for one cycle. While `pulse_req` stays 1 after that strobe, no new pulse starts.
- R5: When `pulse_req` is 1 and `pulse_en` is 0 in the idle state, no pulse is driven and `req_clear` is 1 for one cycle in the cycle after that edge.
- R6: When the line is held low from outside while the block is not driving, `regs_rst` is 1 in the cycle after the third clock edge following the fall. It is 1 for that single cycle only, however long the low lasts.
- R7: `ram_clr` is a vector with one bit per value slot. When `regs_rst` is 1, only bit `DAC_SLOT` of `ram_clr` is 1. At all other times `ram_clr` is all zeros.
- R8: While the block drives its own pulse, and for `BLANK_CYCLES` cycles after releasing the line, the low level it sees on the line never produces `regs_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_req | input | 1 | Software pulse request bit (level) |
| pulse_en | input | 1 | Pulse output enable from the mask register |
| pin_in | input | 1 | Sensed level of the open-drain line |
| pin_pull_low | output | 1 | 1 = pull the line low; 0 = release it |
| req_clear | output | 1 | One-cycle strobe that clears the request bit |
| regs_rst | output | 1 | One-cycle strobe that resets the register file |
| ram_clr | output | RAM_SLOTS | Per-slot value-storage clear; only the converter slot is ever set |

## Verification
The bench exercises the pulse path with the enable set, using different lengths of request hold after the clear strobe. This separates the exact pulse length and the single-cycle clear from any re-triggering on a request that is still high. It also issues requests with the enable cleared, which shows the reject path is taken instead of a pulse. External low episodes of several lengths confirm the three-edge latency and the once-per-episode strobe, and the per-slot clear vector is compared against a mask holding only the converter slot. Each pulse is followed by a watch window that shows the block's own driven low and the release edge produce no reset.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DRIVE     = 2'd1,
        ST_ACK       = 2'd2,
        ST_WAIT_DROP = 2'd3
    } pulse_state_e;

    typedef struct packed {
        logic pull_low;     // drive the line low
        logic req_clear;    // one-cycle auto-clear of the request bit
        logic release_now;  // last cycle of the driven pulse
    } pulse_ctl_t;

    // A sensed low counts as an external reset only when the block is
    // neither driving nor inside the post-release blanking window.
    function automatic logic qualify_low(input logic pin_sync,
                                         input logic driving,
                                         input logic blanked);
        return !pin_sync && !driving && !blanked;
    endfunction

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstpin_pulse_timer.sv
module rstpin_pulse_timer
    import rstpin_pkg::*;
#(
    parameter int PULSE_CYCLES = 2_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       en,
    output pulse_ctl_t ctl
);
    localparam int            CW   = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

    pulse_state_e  st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        case (st)
            ST_IDLE: begin
                if (req) begin
                    if (en) begin
                        st_n  = ST_DRIVE;
                        cnt_n = '0;
                    end else begin
                        st_n  = ST_ACK;
                    end
                end
            end
            ST_DRIVE: begin
                if (cnt == LAST) st_n  = ST_ACK;
                else             cnt_n = cnt + 1'b1;
            end
            ST_ACK:       st_n = ST_WAIT_DROP;
            ST_WAIT_DROP: if (!req) st_n = ST_IDLE;
            default:      st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        ctl.pull_low    = (st == ST_DRIVE);
        ctl.req_clear   = (st == ST_ACK);
        ctl.release_now = (st == ST_DRIVE) && (cnt == LAST);
    end

    // R2: a pulse only starts after the enable was seen set
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.pull_low) |-> $past(en));

    // R5: a request without enable clears itself and never pulses
    a_r5_reject_clears: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && req && !en) |=> (ctl.req_clear && !ctl.pull_low));

    // R4: a request still high after the clear does not retrigger
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_DROP && req) |=> !ctl.pull_low);
endmodule

// File: rtl/rstpin_in_detect.sv
module rstpin_in_detect
    import rstpin_pkg::*;
#(
    parameter int BLANK_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_sync,
    input  logic driving,
    input  logic release_now,
    output logic strobe
);
    localparam int BW = $clog2(BLANK_CYCLES + 1);

    logic [BW-1:0] blank;
    logic          armed;
    logic          qual;

    assign qual = qualify_low(pin_sync, driving, blank != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            blank  <= '0;
            armed  <= 1'b1;
            strobe <= 1'b0;
        end else begin
            if (release_now)      blank <= BW'(BLANK_CYCLES);
            else if (blank != '0) blank <= blank - 1'b1;

            strobe <= qual && armed;

            if (qual)          armed <= 1'b0;
            else if (pin_sync) armed <= 1'b1;
        end
    end

    // R6: one strobe per low episode, never two in a row
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R8: the block's own driven low never becomes a reset
    a_r8_own_drive_masked: assert property (@(posedge clk) disable iff (rst)
        driving |=> !strobe);
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstpin_pkg::*;
#(
    parameter int PULSE_CYCLES = 2_500_000,
    parameter int BLANK_CYCLES = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int RAM_SLOTS    = 8,
    parameter int DAC_SLOT     = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pulse_req,
    input  logic                 pulse_en,
    input  logic                 pin_in,
    output logic                 pin_pull_low,
    output logic                 req_clear,
    output logic                 regs_rst,
    output logic [RAM_SLOTS-1:0] ram_clr
);
    pulse_ctl_t ctl;
    logic       pin_sync;

    rstpin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    rstpin_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .req (pulse_req),
        .en  (pulse_en),
        .ctl (ctl)
    );

    rstpin_in_detect #(.BLANK_CYCLES(BLANK_CYCLES)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .pin_sync    (pin_sync),
        .driving     (ctl.pull_low),
        .release_now (ctl.release_now),
        .strobe      (regs_rst)
    );

    assign pin_pull_low = ctl.pull_low;
    assign req_clear    = ctl.req_clear;

    // Only the converter-data slot is cleared; all other value slots persist.
    generate
        for (genvar g = 0; g < RAM_SLOTS; g++) begin : g_slot
            if (g == DAC_SLOT) begin : g_dac
                assign ram_clr[g] = regs_rst;
            end else begin : g_keep
                assign ram_clr[g] = 1'b0;
            end
        end
    endgenerate

    // Checker counter for the pulse length window
    int unsigned run_len;
    always_ff @(posedge clk) begin
        if (rst)               run_len <= 0;
        else if (pin_pull_low) run_len <= run_len + 1;
        else                   run_len <= 0;
    end

    // R3: the driven low lasts exactly the configured length
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_pull_low) |-> (run_len == PULSE_CYCLES));

    // R4: release of the line is followed by the auto-clear strobe
    a_r4_clear_follows: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_pull_low) |-> req_clear);

    // R7: any storage clear only comes with a register reset
    a_r7_ram_spared: assert property (@(posedge clk) disable iff (rst)
        (ram_clr != '0) |-> (regs_rst && $onehot0(ram_clr)));

    // R1: quiet outputs in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!pin_pull_low && !req_clear && !regs_rst));
endmodule

// File: tb/tb_rstpin_ctrl.sv
module tb_rstpin_ctrl;
    localparam int PULSE = 24;
    localparam int BLANK = 3;
    localparam int SLOTS = 8;
    localparam int DAC   = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             en  = 1'b0;
    logic             ext_low = 1'b0;
    logic             pin_in;
    logic             pull_low, req_clear, regs_rst;
    logic [SLOTS-1:0] ram_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // open-drain line with pull-up
    assign pin_in = !(pull_low || ext_low);

    rstpin_ctrl #(
        .PULSE_CYCLES(PULSE), .BLANK_CYCLES(BLANK), .SYNC_STAGES(2),
        .RAM_SLOTS(SLOTS), .DAC_SLOT(DAC)
    ) dut (
        .clk(clk), .rst(rst), .pulse_req(req), .pulse_en(en), .pin_in(pin_in),
        .pin_pull_low(pull_low), .req_clear(req_clear), .regs_rst(regs_rst),
        .ram_clr(ram_clr)
    );

    function automatic logic [SLOTS-1:0] exp_ram(input logic strobe);
        return strobe ? (SLOTS'(1) << DAC) : '0;
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_pulse(input bit e, input int hold);
        int len;
        en  = e;
        req = 1'b1;
        step();
        if (e) begin
            check(pull_low == 1'b1, "R2", "pull_low after request", int'(pull_low), 1);
            len = 1;
            while (len < PULSE + 10) begin
                check(regs_rst == 1'b0, "R8", "reset during own pulse", int'(regs_rst), 0);
                step();
                if (pull_low) len++;
                else break;
            end
            check(len == PULSE, "R3", "pulse length", len, PULSE);
            check(req_clear == 1'b1, "R4", "clear after pulse", int'(req_clear), 1);
        end else begin
            check(pull_low == 1'b0, "R5", "no pulse when disabled", int'(pull_low), 0);
            check(req_clear == 1'b1, "R5", "clear when disabled", int'(req_clear), 1);
        end
        for (int i = 0; i < hold; i++) begin
            step();
            check(pull_low == 1'b0 && req_clear == 1'b0, "R4",
                  "no retrigger while request held", int'({pull_low, req_clear}), 0);
        end
        req = 1'b0;
        for (int i = 0; i < BLANK + 3; i++) begin
            step();
            check(regs_rst == 1'b0 && pull_low == 1'b0, "R8", "quiet after release",
                  int'({regs_rst, pull_low}), 0);
        end
    endtask

    task automatic ext_reset(input int len);
        ext_low = 1'b1;
        step();
        check(regs_rst == 1'b0, "R6", "latency edge 1", int'(regs_rst), 0);
        step();
        check(regs_rst == 1'b0, "R6", "latency edge 2", int'(regs_rst), 0);
        step();
        check(regs_rst == 1'b1, "R6", "strobe at edge 3", int'(regs_rst), 1);
        check(ram_clr == exp_ram(1'b1), "R7", "slot clear vector", int'(ram_clr),
              int'(exp_ram(1'b1)));
        for (int i = 3; i < len; i++) begin
            step();
            check(regs_rst == 1'b0, "R6", "single strobe per episode", int'(regs_rst), 0);
            check(ram_clr == exp_ram(1'b0), "R7", "slots kept", int'(ram_clr), 0);
        end
        ext_low = 1'b0;
        repeat (4) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        check({pull_low, req_clear, regs_rst} == 3'b000 && ram_clr == '0, "R1",
              "outputs in reset", int'({pull_low, req_clear, regs_rst}), 0);
        rst = 1'b0;
        step();
        check({pull_low, req_clear, regs_rst} == 3'b000 && ram_clr == '0, "R1",
              "outputs after reset", int'({pull_low, req_clear, regs_rst}), 0);

        // directed corners
        do_pulse(1'b1, 0);
        do_pulse(1'b1, 5);
        do_pulse(1'b0, 3);
        ext_reset(3);
        ext_reset(12);

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            int op;
            int idle;
            idle = int'($urandom_range(0, 3));
            for (int k = 0; k < idle; k++) begin
                step();
                check(regs_rst == 1'b0 && pull_low == 1'b0, "R6", "idle quiet",
                      int'({regs_rst, pull_low}), 0);
            end
            op = int'($urandom_range(0, 2));
            case (op)
                0:       do_pulse(1'b1, int'($urandom_range(0, 4)));
                1:       do_pulse(1'b0, int'($urandom_range(0, 4)));
                default: ext_reset(int'($urandom_range(3, 9)));
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule